// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of an SDRAM read or write burst. When a command starts, it captures the start column and the burst settings. It then puts out one column per enabled clock, marks the beat that ends a fixed-length burst, and stops early on a terminate strobe. Columns always stay inside the window that is aligned to the burst length. The order within that window is either sequential or interleaved.

The burst length code and the type bit come from the controller's copy of the mode setting. A separate single-write setting makes every write a one-column access, while reads keep the programmed length. A full-page burst steps through all columns of the row, wrapping at the top, and runs until it is terminated or a new command starts. The clock enable freezes all internal state.

Top module: `sdr_burst_colgen`

## Requirements
- R1: While `ce` is high, a `start` at a clock edge makes `beat_valid` high in the next cycle, with `col_out` equal to the sampled `col_start` (beat 0).
- R2: `bl_code` selects the burst length: 3'b000 = 1, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8, 3'b111 = full page. The reserved codes 3'b100 to 3'b110 give a single beat.
- R3: With `bt_ilv` = 0 and a burst length BL of 2, 4 or 8, beat k puts out the start column with its low log2(BL) bits replaced by (start low bits + k) mod BL. The upper bits stay fixed.
- R4: With `bt_ilv` = 1 and BL of 2, 4 or 8, beat k puts out the start column with its low log2(BL) bits replaced by (start low bits XOR k).
- R5: A full-page burst always runs in sequential order, whatever `bt_ilv` is. Beat k is (start + k) mod 1024, and the burst continues past 1024 beats until a terminate or a new start.
- R6: `last_beat` is high exactly on beat BL-1 of a fixed-length burst and never during a full-page burst. An enabled edge on the last beat without `start` ends the burst, so `beat_valid` is low in the next cycle.
- R7: An enabled edge with `term` high and `start` low ends an active burst, so `beat_valid` is low in the next cycle.
- R8: While `ce` is low, `col_out`, `beat_valid` and `last_beat` hold their values, and `start` and `term` have no effect.
- R9: A start with `is_write` = 1 and `wr_single` = 1 gives a single beat. Reads, and writes with `wr_single` = 0, use the programmed length.
- R10: A `start` during an active burst has priority over `term` and over the end of the last beat. It begins the new burst with the new settings in the next cycle.
- R11: After reset, `beat_valid` and `last_beat` are low and `col_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Clock enable; when low, all state holds |
| start | input | 1 | Begin a burst (read or write command accepted) |
| is_write | input | 1 | The starting command is a write |
| term | input | 1 | Terminate the active burst (terminate or precharge) |
| col_start | input | 10 | Start column of the burst |
| bl_code | input | 3 | Burst length code |
| bt_ilv | input | 1 | Burst type: 0 sequential, 1 interleaved |
| wr_single | input | 1 | Writes are single-column accesses |
| col_out | output | 10 | Column address of the current beat |
| beat_valid | output | 1 | A burst beat is present this cycle |
| last_beat | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
Two functions can fall in the same cycle: a new start and the end of a running burst. The end can come from a terminate strobe or from the last beat. The bench provokes both cases. It raises `start` together with `term` in the middle of an eight-beat burst, and it raises `start` exactly on the cycle where `last_beat` is high. In each case the next cycle must show `beat_valid` still high and `col_out` equal to the new start column, and the rest of the new burst must follow its own length and order. A third overlap is a `start` or `term` given while `ce` is low. There the outputs must hold, and the burst must then resume where it left off.

// File: rtl/sdr_burst_pkg.sv
// Package: shared burst-length encodings for the column generator.
// Assumes a 3-bit length code; any unlisted value counts as a single beat.
package sdr_burst_pkg;
    typedef enum logic [2:0] {
        BLC_1    = 3'b000,
        BLC_2    = 3'b001,
        BLC_4    = 3'b010,
        BLC_8    = 3'b011,
        BLC_FULL = 3'b111
    } blen_code_e;
endpackage

// File: rtl/sdr_burst_cfg.sv
// Module: sdr_burst_cfg
// Turns the length code, type bit and write/single-write setting into a
// window mask (BL-1), a full-page flag and an effective interleave flag.
// Assumes COL_W >= 3 so the eight-beat mask fits.
module sdr_burst_cfg
    import sdr_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [2:0]       bl_code,
    input  logic             bt_ilv,
    input  logic             is_write,
    input  logic             wr_single,
    output logic [COL_W-1:0] mask,
    output logic             full,
    output logic             ilv
);
    // Decode length code into window mask, honouring single-column writes.
    always_comb begin
        mask = '0;
        full = 1'b0;
        if (!(is_write && wr_single)) begin
            case (bl_code)
                BLC_2:    mask = COL_W'(1);
                BLC_4:    mask = COL_W'(3);
                BLC_8:    mask = COL_W'(7);
                BLC_FULL: begin
                    mask = '1;
                    full = 1'b1;
                end
                default:  mask = '0;
            endcase
        end
        ilv = bt_ilv && !full;
    end
endmodule

// File: rtl/sdr_burst_ctrl.sv
// Module: sdr_burst_ctrl
// Holds the burst state: validity, start column, beat counter and the
// captured settings. Start wins over terminate and over the last-beat end.
// Assumes the beat counter wraps naturally at 2**COL_W (full page).
module sdr_burst_ctrl #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             start,
    input  logic             term,
    input  logic [COL_W-1:0] col_start,
    input  logic [COL_W-1:0] cfg_mask,
    input  logic             cfg_full,
    input  logic             cfg_ilv,
    output logic             valid_q,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] cnt_q,
    output logic [COL_W-1:0] mask_q,
    output logic             full_q,
    output logic             ilv_q,
    output logic             last
);
    // Final beat of a fixed-length burst.
    assign last = valid_q && !full_q && (cnt_q == mask_q);

    // Burst state update, gated by the clock enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            base_q  <= '0;
            cnt_q   <= '0;
            mask_q  <= '0;
            full_q  <= 1'b0;
            ilv_q   <= 1'b0;
        end else if (ce) begin
            if (start) begin
                valid_q <= 1'b1;
                base_q  <= col_start;
                cnt_q   <= '0;
                mask_q  <= cfg_mask;
                full_q  <= cfg_full;
                ilv_q   <= cfg_ilv;
            end else if (valid_q && (term || last)) begin
                valid_q <= 1'b0;
            end else if (valid_q) begin
                cnt_q <= cnt_q + COL_W'(1);
            end
        end
    end
endmodule

// File: rtl/sdr_burst_colmap.sv
// Module: sdr_burst_colmap
// Forms the column from start column, beat index and window mask. Bits
// outside the mask come from the start column; bits inside come from the
// sum (sequential) or the XOR (interleaved). Purely combinational.
module sdr_burst_colmap #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] seq_sum;
    logic [COL_W-1:0] ilv_mix;

    // Candidate low-bit values for both orderings.
    assign seq_sum = base + cnt;
    assign ilv_mix = base ^ cnt;

    // Per-bit select between fixed upper bits and the ordered low bits.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col[i] = mask[i] ? (ilv ? ilv_mix[i] : seq_sum[i]) : base[i];
    end
endmodule

// File: rtl/sdr_burst_colgen.sv
// Module: sdr_burst_colgen (top)
// SDRAM burst column generator: captures a start column and burst settings
// on start, then emits one column per enabled clock, with last-beat flag,
// early termination and burst-aligned wrap. Assumes synchronous active-low
// reset and that the caller asserts start only for read/write commands.
module sdr_burst_colgen #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             start,
    input  logic             is_write,
    input  logic             term,
    input  logic [COL_W-1:0] col_start,
    input  logic [2:0]       bl_code,
    input  logic             bt_ilv,
    input  logic             wr_single,
    output logic [COL_W-1:0] col_out,
    output logic             beat_valid,
    output logic             last_beat
);
    logic [COL_W-1:0] cfg_mask;
    logic             cfg_full;
    logic             cfg_ilv;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] cnt_q;
    logic [COL_W-1:0] mask_q;
    logic             full_q;
    logic             ilv_q;

    sdr_burst_cfg #(.COL_W(COL_W)) u_cfg (
        .bl_code   (bl_code),
        .bt_ilv    (bt_ilv),
        .is_write  (is_write),
        .wr_single (wr_single),
        .mask      (cfg_mask),
        .full      (cfg_full),
        .ilv       (cfg_ilv)
    );

    sdr_burst_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .start     (start),
        .term      (term),
        .col_start (col_start),
        .cfg_mask  (cfg_mask),
        .cfg_full  (cfg_full),
        .cfg_ilv   (cfg_ilv),
        .valid_q   (beat_valid),
        .base_q    (base_q),
        .cnt_q     (cnt_q),
        .mask_q    (mask_q),
        .full_q    (full_q),
        .ilv_q     (ilv_q),
        .last      (last_beat)
    );

    sdr_burst_colmap #(.COL_W(COL_W)) u_map (
        .base (base_q),
        .cnt  (cnt_q),
        .mask (mask_q),
        .ilv  (ilv_q),
        .col  (col_out)
    );
endmodule

// File: rtl/sdr_burst_colgen_chk.sv
// Module: sdr_burst_colgen_chk
// Property checker for the column generator, attached by bind. Observes
// ports plus the captured full-page flag.
module sdr_burst_colgen_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce,
    input logic             start,
    input logic             term,
    input logic [COL_W-1:0] col_start,
    input logic [COL_W-1:0] col_out,
    input logic             beat_valid,
    input logic             last_beat,
    input logic             full_q
);
    // R1: an enabled start yields beat 0 at the start column.
    p_first_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && start) |=> (beat_valid && col_out == $past(col_start)));

    // R8: clock enable low freezes the outputs.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(col_out) && $stable(beat_valid) && $stable(last_beat)));

    // R6: the last beat ends the burst unless a new start arrives.
    p_end_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && last_beat && !start) |=> !beat_valid);

    // R7: terminate ends an active burst.
    p_term_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && term && !start) |=> !beat_valid);

    // R5: a full-page burst keeps running without terminate.
    p_full_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && beat_valid && full_q && !term && !start) |=> beat_valid);
endmodule

bind sdr_burst_colgen sdr_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce         (ce),
    .start      (start),
    .term       (term),
    .col_start  (col_start),
    .col_out    (col_out),
    .beat_valid (beat_valid),
    .last_beat  (last_beat),
    .full_q     (full_q)
);

// File: tb/sdr_burst_colgen_test.sv
// Directed bench for sdr_burst_colgen: one task per scenario.
module sdr_burst_colgen_test;
    localparam int CLK_PERIOD = 10;
    localparam int COLS       = 1024;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ce, start, is_write, term, bt_ilv, wr_single;
    logic [9:0] col_start;
    logic [2:0] bl_code;
    logic [9:0] col_out;
    logic       beat_valid, last_beat;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdr_burst_colgen uut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .start(start), .is_write(is_write),
        .term(term), .col_start(col_start), .bl_code(bl_code), .bt_ilv(bt_ilv),
        .wr_single(wr_single), .col_out(col_out), .beat_valid(beat_valid),
        .last_beat(last_beat)
    );

    // Advance one edge and sample away from it.
    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected column from the requirement text (modular form).
    function automatic int exp_col(input int base, input int k, input int bl, input bit il);
        int lo;
        lo = base % bl;
        if (il) return base - lo + (lo ^ k);
        return base - lo + ((lo + k) % bl);
    endfunction

    task automatic idle_inputs();
        ce = 1'b1; start = 1'b0; term = 1'b0; is_write = 1'b0;
        wr_single = 1'b0; bt_ilv = 1'b0; bl_code = 3'b000; col_start = '0;
    endtask

    task automatic issue(input int base, input logic [2:0] code, input bit il,
                         input bit wr, input bit sgl);
        col_start = 10'(base); bl_code = code; bt_ilv = il;
        is_write = wr; wr_single = sgl; start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    // Walk the burst beats and check column, valid, last; then the end.
    task automatic walk(input string req, input int base, input int bl, input bit il);
        for (int k = 0; k < bl; k++) begin
            chk(req, {31'd0, beat_valid}, 1);
            chk(req, int'(col_out), exp_col(base, k, bl, il));
            chk({req, " R6 last"}, {31'd0, last_beat}, (k == bl - 1) ? 1 : 0);
            tick();
        end
        chk({req, " R6 end"}, {31'd0, beat_valid}, 0);
    endtask

    task automatic t_reset();
        idle_inputs();
        rst_n = 1'b0;
        tick(); tick();
        chk("R11 valid", {31'd0, beat_valid}, 0);
        chk("R11 last", {31'd0, last_beat}, 0);
        chk("R11 col", int'(col_out), 0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_sequential();
        issue('h3FD, 3'b011, 0, 0, 0); walk("R3 seq8", 'h3FD, 8, 0);
        issue('h0A1, 3'b010, 0, 0, 0); walk("R3 seq4", 'h0A1, 4, 0);
        issue('h101, 3'b001, 0, 0, 0); walk("R2 seq2", 'h101, 2, 0);
        issue('h2C7, 3'b000, 0, 0, 0); walk("R2 len1", 'h2C7, 1, 0);
    endtask

    task automatic t_interleave();
        issue('h0A6, 3'b011, 1, 0, 0); walk("R4 ilv8", 'h0A6, 8, 1);
        issue('h003, 3'b010, 1, 0, 0); walk("R4 ilv4", 'h003, 4, 1);
        issue('h155, 3'b001, 1, 0, 0); walk("R4 ilv2", 'h155, 2, 1);
    endtask

    task automatic t_reserved();
        issue('h042, 3'b101, 0, 0, 0); walk("R2 reserved", 'h042, 1, 0);
    endtask

    task automatic t_full_page(input bit il);
        issue('h3FE, 3'b111, il, 0, 0);
        for (int k = 0; k < COLS + 6; k++) begin
            chk("R5 full valid", {31'd0, beat_valid}, 1);
            chk("R5 full col", int'(col_out), ('h3FE + k) % COLS);
            chk("R6 full no last", {31'd0, last_beat}, 0);
            tick();
        end
        term = 1'b1; tick(); term = 1'b0;
        chk("R7 full term", {31'd0, beat_valid}, 0);
    endtask

    task automatic t_terminate();
        issue('h210, 3'b011, 0, 0, 0);
        tick(); tick();
        chk("R7 pre", int'(col_out), 'h212);
        term = 1'b1; tick(); term = 1'b0;
        chk("R7 term", {31'd0, beat_valid}, 0);
    endtask

    task automatic t_ce_hold();
        issue('h3F4, 3'b011, 1, 0, 0);
        tick();
        chk("R8 before", int'(col_out), exp_col('h3F4, 1, 8, 1));
        ce = 1'b0; start = 1'b1; term = 1'b1; col_start = 10'h111;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R8 hold col", int'(col_out), exp_col('h3F4, 1, 8, 1));
            chk("R8 hold valid", {31'd0, beat_valid}, 1);
        end
        start = 1'b0; term = 1'b0; ce = 1'b1;
        tick();
        for (int k = 2; k < 8; k++) begin
            chk("R8 resume", int'(col_out), exp_col('h3F4, k, 8, 1));
            chk("R8 resume last", {31'd0, last_beat}, (k == 7) ? 1 : 0);
            tick();
        end
        chk("R8 end", {31'd0, beat_valid}, 0);
    endtask

    task automatic t_single_write();
        issue('h0F3, 3'b011, 0, 1, 1); walk("R9 wr single", 'h0F3, 1, 0);
        issue('h0F3, 3'b011, 0, 1, 0); walk("R9 wr burst", 'h0F3, 8, 0);
        issue('h0F3, 3'b011, 0, 0, 1); walk("R9 rd burst", 'h0F3, 8, 0);
    endtask

    task automatic t_start_overlap();
        // Start together with terminate mid-burst.
        issue('h080, 3'b011, 0, 0, 0);
        tick();
        col_start = 10'h1C5; bl_code = 3'b010; bt_ilv = 1'b1;
        start = 1'b1; term = 1'b1;
        tick();
        start = 1'b0; term = 1'b0;
        walk("R10 start+term", 'h1C5, 4, 1);
        // Start on the last beat: back-to-back bursts.
        issue('h033, 3'b001, 0, 0, 0);
        tick();
        chk("R10 on last", {31'd0, last_beat}, 1);
        col_start = 10'h2EE; bl_code = 3'b011; bt_ilv = 1'b0; start = 1'b1;
        tick();
        start = 1'b0;
        walk("R10 back2back", 'h2EE, 8, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_sequential();
        t_interleave();
        t_reserved();
        t_full_page(1'b0);
        t_full_page(1'b1);
        t_terminate();
        t_ce_hold();
        t_single_write();
        t_start_overlap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule